// File: doc/BRIEF.md
# Scratchpad Chunk Shuffle-Add Unit

This unit carries out the neighbour-mixing step of a memory-hard hash main loop. Given a 16-byte-aligned scratchpad offset, it picks the three sibling 128-bit chunks that share the offset's 64-byte group. It reads all three, then writes each one back as a lane-wise sum of a different old chunk and one of the loop registers (`b0`, `b1` or `a`). In the extended mode it also XOR-folds the three pre-update chunk values into a 128-bit working value.

The scratchpad sits outside the block and is reached through a single synchronous port. That port takes a 17-bit chunk index and returns read data one cycle after the read request. A transaction begins with a one-cycle `start` and ends with a one-cycle `done`. The updated working value is on `work_out` while `done` is high.

Top module: `chunk_shuffle_add`

## Requirements
- R1: With k = offset[20:4], the three chunks touched are chunk indices k^1, k^2 and k^3, called chunk 1, 2 and 3. This is byte offset XOR 0x10, 0x20 and 0x30. Chunk k itself is never accessed.
- R2: After a mode 2 or higher step: new chunk 1 = old chunk 3 + b1, new chunk 2 = old chunk 1 + b0, and new chunk 3 = old chunk 2 + a.
- R3: Each sum is formed on two independent 64-bit lanes, bits [63:0] and [127:64]. Each lane wraps modulo 2^64, and no carry passes from the low lane into the high lane.
- R4: All three reads are issued, in the order chunk 1, 2, 3, before the first write. The writes then follow in the order chunk 1, 2, 3. Read and write are never requested in the same cycle.
- R5: When mode is 0 or 1, no read or write is issued, and `done` still pulses.
- R6: When mode is 2 or 3, `work_out` equals `work_in` as captured at start.
- R7: When mode is 4 or higher, `work_out` = work_in ^ old chunk 3 ^ old chunk 1 ^ old chunk 2.
- R8: A 128-bit memory word holds byte n at bits [8n+7:8n]. The low 64-bit lane is therefore the little-endian word formed by bytes 0 to 7.
- R9: offset[3:0] has no effect on the chunks selected.
- R10: `done` is high for exactly one cycle per accepted start. A start that arrives while `busy` is high is ignored.
- R11: While reset is high, `done`, `busy`, `mem_re` and `mem_we` are 0 and `work_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a step; accepted only when idle |
| offset | input | 21 | Scratchpad byte offset |
| mode | input | 3 | Algorithm mode |
| b0_in | input | 128 | Register b, low half |
| b1_in | input | 128 | Register b, high half |
| a_in | input | 128 | Register a |
| work_in | input | 128 | Working value to fold |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| work_out | output | 128 | Resulting working value |
| mem_re | output | 1 | Scratchpad read request |
| mem_we | output | 1 | Scratchpad write request |
| mem_addr | output | 17 | Scratchpad chunk index |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, one cycle after `mem_re` |

## Verification
The hardest case to reach from the ports is a lane that overflows, because only a carry leaking from the low lane into the high lane would reveal a faulty adder. The stimulus pokes all-ones chunks into the modelled scratchpad and adds one to both lanes. The expected result is zero in both lanes of every chunk. A second hard case is a start pulse that arrives mid-transaction with a different offset. It is driven while reads are in flight, and the bench then confirms that exactly three writes landed on the original chunks.

// File: rtl/chunk_sa_pkg.sv
package chunk_sa_pkg;
  localparam int NCHUNK      = 3;
  localparam int SLOT_W      = 2;
  localparam int SHUFFLE_MIN = 2;
  localparam int FOLD_MIN    = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_DRAIN,
    S_WRITE,
    S_FIN
  } sa_state_e;
endpackage

// File: rtl/chunk_lane_add.sv
module chunk_lane_add #(
  parameter int LANE_W = 64,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  // independent lanes: no carry crosses a lane boundary
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign s[l*LANE_W +: LANE_W] = x[l*LANE_W +: LANE_W] + y[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/chunk_xor_fold.sv
module chunk_xor_fold #(
  parameter int W = 128
) (
  input  logic [W-1:0] work,
  input  logic [W-1:0] c1,
  input  logic [W-1:0] c2,
  input  logic [W-1:0] c3,
  output logic [W-1:0] folded
);
  assign folded = work ^ c3 ^ c1 ^ c2;
endmodule

// File: rtl/chunk_sa_ctrl.sv
module chunk_sa_ctrl
  import chunk_sa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              use_mem,
  output logic              accept,
  output logic              busy,
  output logic              rd_en,
  output logic              wr_en,
  output logic [SLOT_W-1:0] slot,
  output logic              cap_v,
  output logic [SLOT_W-1:0] cap_slot,
  output logic              fin
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NCHUNK - 1);

  sa_state_e         st;
  logic [SLOT_W-1:0] cnt;

  assign accept = (st == S_IDLE) && start;
  assign busy   = (st != S_IDLE);
  assign rd_en  = (st == S_READ);
  assign wr_en  = (st == S_WRITE);
  assign fin    = (st == S_FIN);
  assign slot   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cap_v    <= 1'b0;
      cap_slot <= '0;
    end else begin
      cap_v    <= rd_en;
      cap_slot <= cnt;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) st <= use_mem ? S_READ : S_FIN;
        end
        S_READ: begin
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_DRAIN;
          end else cnt <= cnt + 1'b1;
        end
        S_DRAIN: st <= S_WRITE;
        S_WRITE: begin
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4: the last capture must land before the first write is issued
  p_capture_before_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(cap_v) && ($past(cap_slot) == LAST));
endmodule

// File: rtl/chunk_shuffle_add.sv
module chunk_shuffle_add
  import chunk_sa_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int MODE_W   = 3,
  parameter int LANE_W   = 64,
  parameter int LANES    = 2,
  localparam int CHUNK_W = LANE_W * LANES,
  localparam int OFS_LSB = $clog2(CHUNK_W / 8),
  localparam int IDX_W   = ADDR_W - OFS_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [MODE_W-1:0]  mode,
  input  logic [CHUNK_W-1:0] b0_in,
  input  logic [CHUNK_W-1:0] b1_in,
  input  logic [CHUNK_W-1:0] a_in,
  input  logic [CHUNK_W-1:0] work_in,
  output logic               done,
  output logic               busy,
  output logic [CHUNK_W-1:0] work_out,
  output logic               mem_re,
  output logic               mem_we,
  output logic [IDX_W-1:0]   mem_addr,
  output logic [CHUNK_W-1:0] mem_wdata,
  input  logic [CHUNK_W-1:0] mem_rdata
);
  logic [IDX_W-1:0]   base_q;
  logic [MODE_W-1:0]  mode_q;
  logic [CHUNK_W-1:0] b0_q, b1_q, a_q, work_q;
  logic [CHUNK_W-1:0] old_q  [NCHUNK];
  logic [CHUNK_W-1:0] addend [NCHUNK];
  logic [CHUNK_W-1:0] sum    [NCHUNK];
  logic [CHUNK_W-1:0] folded;

  logic              accept, rd_en, wr_en, cap_v, fin;
  logic [SLOT_W-1:0] slot, cap_slot;
  logic              use_mem, fold_en;

  assign use_mem = (mode >= MODE_W'(SHUFFLE_MIN));
  assign fold_en = (mode_q >= MODE_W'(FOLD_MIN));

  chunk_sa_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .use_mem (use_mem),
    .accept  (accept),
    .busy    (busy),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .slot    (slot),
    .cap_v   (cap_v),
    .cap_slot(cap_slot),
    .fin     (fin)
  );

  // capture all loop operands at start; low offset bits drop out in the shift
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
      a_q    <= '0;
      work_q <= '0;
    end else if (accept) begin
      base_q <= IDX_W'(offset >> OFS_LSB);
      mode_q <= mode;
      b0_q   <= b0_in;
      b1_q   <= b1_in;
      a_q    <= a_in;
      work_q <= work_in;
    end
  end

  // old chunk values, all held until the last write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCHUNK; i++) old_q[i] <= '0;
    end else if (cap_v) begin
      old_q[cap_slot] <= mem_rdata;
    end
  end

  always_comb begin
    addend[0] = b1_q;
    addend[1] = b0_q;
    addend[2] = a_q;
  end

  // new chunk g takes the old chunk one position behind it in the ring
  for (genvar g = 0; g < NCHUNK; g++) begin : g_sum
    chunk_lane_add #(
      .LANE_W(LANE_W),
      .LANES (LANES)
    ) u_add (
      .x(old_q[(g + NCHUNK - 1) % NCHUNK]),
      .y(addend[g]),
      .s(sum[g])
    );
  end

  chunk_xor_fold #(.W(CHUNK_W)) u_fold (
    .work  (work_q),
    .c1    (old_q[0]),
    .c2    (old_q[1]),
    .c3    (old_q[2]),
    .folded(folded)
  );

  assign mem_re    = rd_en;
  assign mem_we    = wr_en;
  assign mem_addr  = base_q ^ IDX_W'(slot + 1'b1);
  assign mem_wdata = sum[slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      work_out <= '0;
    end else begin
      done <= fin;
      if (fin) work_out <= fold_en ? folded : work_q;
    end
  end

  // R4: one port, one direction per cycle
  p_rw_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: low modes keep the scratchpad port silent
  p_low_mode_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q < MODE_W'(SHUFFLE_MIN)) |-> !(mem_re || mem_we));

  // R1: the chunk named by the offset itself is never addressed
  p_own_chunk_untouched_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_re || mem_we) |-> (mem_addr != base_q));

  // R6: the working result only moves together with done
  p_work_moves_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(work_out) |-> done);
endmodule

// File: tb/chunk_shuffle_add_bench.sv
`timescale 1ns/1ps
module chunk_shuffle_add_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [20:0]  offset;
  logic [2:0]   mode;
  logic [127:0] b0_in, b1_in, a_in, work_in;
  logic         done, busy;
  logic [127:0] work_out;
  logic         mem_re, mem_we;
  logic [16:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  chunk_shuffle_add u_chunk_shuffle_add (
    .clk(clk), .rst(rst), .start(start), .offset(offset), .mode(mode),
    .b0_in(b0_in), .b1_in(b1_in), .a_in(a_in), .work_in(work_in),
    .done(done), .busy(busy), .work_out(work_out),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [127:0] fill(input logic [31:0] s);
    return {s * 32'd3 + 32'd1, s ^ 32'hA5A5_5A5A, ~s, s * 32'h9E37_79B9};
  endfunction

  function automatic logic [127:0] ladd(input logic [127:0] x, input logic [127:0] y);
    return {x[127:64] + y[127:64], x[63:0] + y[63:0]};
  endfunction

  // scratchpad model: one-cycle read latency, unwritten chunks hold a seed pattern
  logic [127:0] mem [logic [16:0]];
  int rd_cnt, wr_cnt, cyc, last_rd, first_wr;
  logic [16:0] wr_log [3];

  function automatic logic [127:0] peek(input logic [16:0] i);
    return mem.exists(i) ? mem[i] : fill({15'd0, i} ^ 32'h1234_0000);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_re) begin
      mem_rdata <= peek(mem_addr);
      rd_cnt    <= rd_cnt + 1;
      last_rd   <= cyc;
    end
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      if (wr_cnt < 3) wr_log[wr_cnt] <= mem_addr;
      if (wr_cnt == 0) first_wr <= cyc;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input string tag, input logic [20:0] off, input logic [2:0] md,
                         input logic [127:0] vb0, input logic [127:0] vb1,
                         input logic [127:0] va, input logic [127:0] vw, input bit restart);
    logic [16:0]  k  = off[20:4];
    logic [127:0] o1 = peek(k ^ 17'd1);
    logic [127:0] o2 = peek(k ^ 17'd2);
    logic [127:0] o3 = peek(k ^ 17'd3);
    logic [127:0] ok0 = peek(k);
    bit shuffle = (md >= 3'd2);
    logic [127:0] e1 = shuffle ? ladd(o3, vb1) : o1;
    logic [127:0] e2 = shuffle ? ladd(o1, vb0) : o2;
    logic [127:0] e3 = shuffle ? ladd(o2, va)  : o3;
    logic [127:0] ew = (md >= 3'd4) ? (vw ^ o3 ^ o1 ^ o2) : vw;
    int n = 0;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; first_wr = 0; last_rd = 0;
    start = 1'b1; offset = off; mode = md;
    b0_in = vb0; b1_in = vb1; a_in = va; work_in = vw;
    @(negedge clk);
    start = 1'b0; offset = ~off; mode = 3'd0;
    b0_in = ~vb0; b1_in = ~vb1; a_in = ~va; work_in = ~vw;
    if (restart) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R10 done seen"}, {127'd0, done}, 128'd1);
    chk({tag, (md >= 3'd4) ? " R7 work fold" : " R6/R5 work pass"}, work_out, ew);
    chk({tag, " R4/R5 read count"}, 128'(rd_cnt), shuffle ? 128'd3 : 128'd0);
    chk({tag, " R4/R5 write count"}, 128'(wr_cnt), shuffle ? 128'd3 : 128'd0);
    if (shuffle) begin
      chk({tag, " R1 write order 1"}, 128'(wr_log[0]), 128'(k ^ 17'd1));
      chk({tag, " R1 write order 2"}, 128'(wr_log[1]), 128'(k ^ 17'd2));
      chk({tag, " R1 write order 3"}, 128'(wr_log[2]), 128'(k ^ 17'd3));
      chk({tag, " R4 reads before writes"}, 128'(last_rd < first_wr), 128'd1);
    end
    chk({tag, " R2 chunk1"}, peek(k ^ 17'd1), e1);
    chk({tag, " R2 chunk2"}, peek(k ^ 17'd2), e2);
    chk({tag, " R2 chunk3"}, peek(k ^ 17'd3), e3);
    chk({tag, " R1 own chunk unchanged"}, peek(k), ok0);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, {127'd0, done}, 128'd0);
  endtask

  // offset, mode, seed
  localparam logic [55:0] VEC [6] = '{
    {21'h000040, 3'd2, 32'd1},
    {21'h1FFFF0, 3'd3, 32'd2},
    {21'h00123F, 3'd4, 32'd3},
    {21'h0ABCD5, 3'd7, 32'd4},
    {21'h000000, 3'd0, 32'd5},
    {21'h054320, 3'd1, 32'd6}
  };

  initial begin
    rst = 1'b1; start = 1'b0; offset = '0; mode = '0;
    b0_in = '0; b1_in = '0; a_in = '0; work_in = '0;
    mem_rdata = '0; cyc = 0; rd_cnt = 0; wr_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset done", {127'd0, done}, 128'd0);
    chk("R11 reset busy", {127'd0, busy}, 128'd0);
    chk("R11 reset mem_re", {127'd0, mem_re}, 128'd0);
    chk("R11 reset mem_we", {127'd0, mem_we}, 128'd0);
    chk("R11 reset work_out", work_out, 128'd0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++) begin
      logic [31:0] s = VEC[i][31:0];
      run_txn($sformatf("vec%0d", i), VEC[i][55:35], VEC[i][34:32],
              fill(s * 11), fill(s * 13), fill(s * 17), fill(s * 19), 1'b0);
    end

    // R9: offset low bits select the same chunks as the aligned offset
    run_txn("R9 low bits", 21'h00777B, 3'd5, fill(21), fill(22), fill(23), fill(24), 1'b0);

    // R3/R8: all-ones lanes plus one wrap to zero, low lane is bits [63:0]
    mem[17'h081] = '1; mem[17'h082] = '1; mem[17'h083] = '1;
    run_txn("R3 carry wrap", 21'h000800, 3'd2, {64'd1, 64'd1}, {64'd1, 64'd1},
            {64'd1, 64'd1}, 128'd0, 1'b0);
    chk("R3 lane isolation chunk1", peek(17'h081), 128'd0);
    mem[17'h093] = {64'd0, 64'hFFFF_FFFF_FFFF_FFFF};
    run_txn("R8 low lane", 21'h000900, 3'd2, 128'd0, {64'd0, 64'd1}, 128'd0, 128'd0, 1'b0);
    chk("R8 low lane carry stays out", peek(17'h091), 128'd0);

    // R10: second start while busy is ignored
    run_txn("R10 start busy", 21'h002340, 3'd4, fill(31), fill(32), fill(33), fill(34), 1'b1);

    // back-to-back low mode then extended mode on the same group
    run_txn("R5 quiet", 21'h002340, 3'd1, fill(41), fill(42), fill(43), fill(44), 1'b0);
    run_txn("R7 repeat", 21'h002340, 3'd6, fill(51), fill(52), fill(53), fill(54), 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule